// File: doc/BRIEF.md
# DAC Stream Buffer with Underflow Hold

This block sits between a set of host-side first-word-fall-through sample queues and a two-channel digital-to-analog converter. A configuration input picks which host queue feeds it. In the system clock domain, words move from that queue into an internal dual-clock FIFO on every cycle where the queue shows data and the FIFO has space.

The converter side runs on an external output clock. Each rising edge of that clock retires one FIFO word to the converter outputs. Each word holds one sample for each channel. In single-channel mode only channel 0 is refreshed.

When the FIFO is empty at an output edge, both outputs keep their last values. An underflow event is then carried back into the system domain, where it lights an indicator for a fixed stretch time. The default stretch is one tenth of a second at a 100 MHz system clock.

Top module: `dac_stream_buf`

## Requirements
- R1: `src_pop[i]` is asserted only for `i == cfg_src`, and only while `src_valid[i]` is high. A queue that is not selected is never popped.
- R2: Words reach the converter in the order they were popped from the host queues. None is lost or repeated.
- R3: The internal FIFO holds at most 2**FIFO_AW words. When it is full, the transfer stops and no pop is issued until space frees up.
- R4: Each rising `dac_clk` edge that finds the FIFO non-empty retires exactly one word. With `cfg_dual = 1`, the word's bits [SAMPLE_W-1:0] go to `dac_ch0` and bits [2*SAMPLE_W-1:SAMPLE_W] go to `dac_ch1`, both on that same edge.
- R5: With `cfg_dual = 0`, each retired word updates only `dac_ch0`, taken from bits [SAMPLE_W-1:0]. `dac_ch1` keeps its value.
- R6: A rising `dac_clk` edge that finds the FIFO empty changes neither output.
- R7: After reset, `dac_ch0` and `dac_ch1` are 0 (mid-scale in two's complement), `led_underflow` is 0, and no pop is issued until a queue shows valid data.
- R8: An empty-FIFO output edge turns `led_underflow` on within a few system cycles. The indicator stays on for STRETCH_CYCLES system cycles after the most recent underflow, then turns off. It stays off when no underflow has occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the host side and the indicator |
| sys_rst_n | input | 1 | Asynchronous active-low reset, system domain |
| cfg_src | input | SRC_W | Index of the host queue to drain |
| src_data | input | NUM_SRC*2*SAMPLE_W | Head word of each host queue, queue i at slice i |
| src_valid | input | NUM_SRC | Host queue i has a word at its head |
| src_pop | output | NUM_SRC | Consume the head word of host queue i |
| dac_clk | input | 1 | External converter update clock |
| dac_rst_n | input | 1 | Asynchronous active-low reset, converter domain |
| cfg_dual | input | 1 | 1: both channels per word, 0: channel 0 only |
| dac_ch0 | output | SAMPLE_W | Channel 0 converter code |
| dac_ch1 | output | SAMPLE_W | Channel 1 converter code |
| led_underflow | output | 1 | Stretched underflow indicator |

## Verification
The assertions rely on a few conditions at the inputs:
- `cfg_src` and `cfg_dual` are quasi-static.
- A host queue's head word stays put until it is popped.
- `dac_clk` is slower than `sys_clk`, so consecutive underflow toggles are never merged by the synchronizer.

The stimulus meets these conditions in three ways:
- It changes the configuration only while the selected queue is empty or the output clock is stopped.
- It updates each queue model only on the falling system edge after a pop.
- It runs the output clock at 36 ns against a 10 ns system clock.

Consecutive test words differ in both halves, so every retirement shows as a change at the outputs.

// File: rtl/dacbuf_pkg.sv
package dacbuf_pkg;
   localparam int unsigned SYNC_DEPTH = 2;

   typedef enum logic {
      MODE_SINGLE = 1'b0,
      MODE_DUAL   = 1'b1
   } chan_mode_e;
endpackage

// File: rtl/dacbuf_sync.sv
module dacbuf_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = dacbuf_pkg::SYNC_DEPTH
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dacbuf_sync: STAGES must be at least 2");
   end

   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) pipe[i] <= '0;
      end else begin
         pipe[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/dacbuf_afifo.sv
module dacbuf_afifo #(
   parameter int unsigned DW = 32,
   parameter int unsigned AW = 4
) (
   input  logic          wclk,
   input  logic          wrst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output logic          wr_full,
   input  logic          rclk,
   input  logic          rrst_n,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic          rd_empty
);
   localparam int unsigned DEPTH = 1 << AW;
   localparam int unsigned PW    = AW + 1;

   if (AW < 1 || AW > 12) begin : g_bad_aw
      $error("dacbuf_afifo: AW must be in 1..12");
   end

   function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = int'(PW) - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wbin, wgray, rgray_at_w, rbin_at_w, wr_used;
   logic [PW-1:0] rbin, rgray, wgray_at_r, wbin_at_r;

   // write side
   always_ff @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (wr_en) begin
         wbin  <= wbin + 1'b1;
         wgray <= to_gray(wbin + 1'b1);
      end
   end

   always_ff @(posedge wclk) begin
      if (wr_en) mem[wbin[AW-1:0]] <= wr_data;
   end

   dacbuf_sync #(.W(PW)) u_rptr_sync (
      .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_at_w)
   );

   assign rbin_at_w = from_gray(rgray_at_w);
   assign wr_used   = wbin - rbin_at_w;
   assign wr_full   = wr_used[AW];

   // read side
   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) begin
         rbin  <= '0;
         rgray <= '0;
      end else if (rd_en) begin
         rbin  <= rbin + 1'b1;
         rgray <= to_gray(rbin + 1'b1);
      end
   end

   dacbuf_sync #(.W(PW)) u_wptr_sync (
      .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_at_r)
   );

   assign wbin_at_r = from_gray(wgray_at_r);
   assign rd_empty  = (wbin_at_r == rbin);
   assign rd_data   = mem[rbin[AW-1:0]];

   AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n)
      wr_en |-> !wr_full);                                    // R3
   AST_USED_BOUND: assert property (@(posedge wclk) disable iff (!wrst_n)
      wr_used <= PW'(DEPTH));                                 // R3
   AST_NO_EMPTY_READ: assert property (@(posedge rclk) disable iff (!rrst_n)
      rd_en |-> !rd_empty);                                   // R6
endmodule

// File: rtl/dacbuf_stretch.sv
module dacbuf_stretch #(
   parameter int unsigned CNT_MAX = 10_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tog_in,
   output logic led
);
   localparam int unsigned CW = $clog2(CNT_MAX + 1);

   if (CNT_MAX < 1) begin : g_bad_cnt
      $error("dacbuf_stretch: CNT_MAX must be at least 1");
   end

   logic          tog_s, tog_prev, evt;
   logic [CW-1:0] cnt;

   dacbuf_sync #(.W(1)) u_tog_sync (
      .clk(clk), .rst_n(rst_n), .d(tog_in), .q(tog_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tog_prev <= 1'b0;
      else        tog_prev <= tog_s;
   end

   assign evt = tog_s ^ tog_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (evt)        cnt <= CW'(CNT_MAX);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign led = (cnt != '0);

   AST_LED_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> led);                                           // R8
   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(CNT_MAX));                                   // R8
endmodule

// File: rtl/dac_stream_buf.sv
module dac_stream_buf
   import dacbuf_pkg::*;
#(
   parameter int unsigned SAMPLE_W       = 16,
   parameter int unsigned FIFO_AW        = 4,
   parameter int unsigned NUM_SRC        = 4,
   parameter int unsigned STRETCH_CYCLES = 10_000_000,
   localparam int unsigned WORD_W        = 2 * SAMPLE_W,
   localparam int unsigned SRC_W         = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic                      sys_clk,
   input  logic                      sys_rst_n,
   input  logic [SRC_W-1:0]          cfg_src,
   input  logic [NUM_SRC*WORD_W-1:0] src_data,
   input  logic [NUM_SRC-1:0]        src_valid,
   output logic [NUM_SRC-1:0]        src_pop,
   input  logic                      dac_clk,
   input  logic                      dac_rst_n,
   input  logic                      cfg_dual,
   output logic [SAMPLE_W-1:0]       dac_ch0,
   output logic [SAMPLE_W-1:0]       dac_ch1,
   output logic                      led_underflow
);
   localparam bit FULL_RANGE = (NUM_SRC == (1 << SRC_W));

   if (SAMPLE_W < 1 || NUM_SRC < 1 || NUM_SRC > 64) begin : g_bad_cfg
      $error("dac_stream_buf: SAMPLE_W >= 1 and NUM_SRC in 1..64 required");
   end

   // ---------------- host side: source select and transfer ----------------
   logic [WORD_W-1:0] sel_word;
   logic              sel_valid, wr_full, xfer;
   logic [WORD_W-1:0] words [NUM_SRC];

   for (genvar i = 0; i < int'(NUM_SRC); i++) begin : g_words
      assign words[i] = src_data[i*WORD_W +: WORD_W];
   end

   if (FULL_RANGE) begin : g_sel_full
      assign sel_valid = src_valid[cfg_src];
      assign sel_word  = words[cfg_src];
   end else begin : g_sel_guard
      logic in_range;
      assign in_range  = ({1'b0, cfg_src} < (SRC_W+1)'(NUM_SRC));
      assign sel_valid = in_range && src_valid[cfg_src];
      assign sel_word  = in_range ? words[cfg_src] : '0;
   end

   assign xfer = sel_valid && !wr_full;

   for (genvar i = 0; i < int'(NUM_SRC); i++) begin : g_pop
      assign src_pop[i] = xfer && (cfg_src == SRC_W'(i));
   end

   // ---------------- crossing buffer ----------------
   logic              rd_empty, rd_en;
   logic [WORD_W-1:0] rd_word;

   dacbuf_afifo #(.DW(WORD_W), .AW(FIFO_AW)) u_fifo (
      .wclk(sys_clk), .wrst_n(sys_rst_n), .wr_en(xfer), .wr_data(sel_word),
      .wr_full(wr_full),
      .rclk(dac_clk), .rrst_n(dac_rst_n), .rd_en(rd_en), .rd_data(rd_word),
      .rd_empty(rd_empty)
   );

   // ---------------- converter side ----------------
   chan_mode_e mode;
   logic       und_tog;

   assign mode  = chan_mode_e'(cfg_dual);
   assign rd_en = !rd_empty;

   always_ff @(posedge dac_clk or negedge dac_rst_n) begin
      if (!dac_rst_n) begin
         dac_ch0 <= '0;
         dac_ch1 <= '0;
         und_tog <= 1'b0;
      end else if (rd_en) begin
         dac_ch0 <= rd_word[SAMPLE_W-1:0];
         if (mode == MODE_DUAL) dac_ch1 <= rd_word[WORD_W-1:SAMPLE_W];
      end else begin
         und_tog <= ~und_tog;
      end
   end

   dacbuf_stretch #(.CNT_MAX(STRETCH_CYCLES)) u_stretch (
      .clk(sys_clk), .rst_n(sys_rst_n), .tog_in(und_tog), .led(led_underflow)
   );

   AST_ONE_SOURCE: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      $onehot0(src_pop));                                     // R1
   AST_POP_NEEDS_VALID: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      (src_pop != '0) |-> ((src_pop & src_valid) != '0));     // R1
   AST_HOLD_ON_EMPTY: assert property (@(posedge dac_clk) disable iff (!dac_rst_n)
      rd_empty |=> ($stable(dac_ch0) && $stable(dac_ch1)));   // R6
   AST_SINGLE_KEEPS_CH1: assert property (@(posedge dac_clk) disable iff (!dac_rst_n)
      !cfg_dual |=> $stable(dac_ch1));                        // R5
endmodule

// File: tb/dac_stream_buf_bench.sv
module dac_stream_buf_bench;
   localparam int SW      = 16;
   localparam int AW      = 3;
   localparam int DEPTH   = 1 << AW;
   localparam int NSRC    = 3;
   localparam int STRETCH = 60;
   localparam int WW      = 2 * SW;

   logic              sys_clk = 1'b0;
   logic              dac_clk = 1'b0;
   logic              dac_run = 1'b0;
   logic              rst_n   = 1'b0;
   logic [1:0]        cfg_src = 2'd0;
   logic              cfg_dual = 1'b1;
   logic [NSRC*WW-1:0] src_data = '0;
   logic [NSRC-1:0]   src_valid = '0;
   logic [NSRC-1:0]   src_pop;
   logic [SW-1:0]     dac_ch0, dac_ch1;
   logic              led_underflow;

   int checks = 0;
   int errors = 0;
   int pop_total = 0;
   int pops_seen = 0;
   int seq = 1;
   bit finished = 1'b0;
   time last_pos = 0;

   logic [WW-1:0] srcq [NSRC][$];
   logic [WW-1:0] mdl_q [$];
   logic [NSRC-1:0] pending = '0;
   logic [SW-1:0] prev0 = '0, prev1 = '0;

   dac_stream_buf #(.SAMPLE_W(SW), .FIFO_AW(AW), .NUM_SRC(NSRC),
                    .STRETCH_CYCLES(STRETCH)) u_dac_stream_buf (
      .sys_clk(sys_clk), .sys_rst_n(rst_n), .cfg_src(cfg_src),
      .src_data(src_data), .src_valid(src_valid), .src_pop(src_pop),
      .dac_clk(dac_clk), .dac_rst_n(rst_n), .cfg_dual(cfg_dual),
      .dac_ch0(dac_ch0), .dac_ch1(dac_ch1), .led_underflow(led_underflow)
   );

   always #5 sys_clk = ~sys_clk;

   initial forever begin
      #18;
      if (dac_run || dac_clk) dac_clk = ~dac_clk;
   end

   always @(posedge dac_clk) last_pos = $time;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [WW-1:0] make_word(input int n);
      logic [SW-1:0] lo;
      lo = SW'(n);
      return {SW'(lo * 3 + 7), lo};
   endfunction

   task automatic push_src(input int s, input int n);
      for (int k = 0; k < n; k++) begin
         srcq[s].push_back(make_word(seq));
         seq++;
      end
   endtask

   task automatic wait_sys(input int n);
      repeat (n) @(posedge sys_clk);
      @(negedge sys_clk);
   endtask

   // host queue model and R1 check, every system cycle
   always @(negedge sys_clk) begin
      if (!rst_n) begin
         pending = '0;
      end else begin
         for (int i = 0; i < NSRC; i++) begin
            if (pending[i] && srcq[i].size() > 0) begin
               mdl_q.push_back(srcq[i].pop_front());
               pop_total++;
            end
         end
         for (int i = 0; i < NSRC; i++) begin
            src_valid[i] = (srcq[i].size() > 0);
            src_data[i*WW +: WW] = (srcq[i].size() > 0) ? srcq[i][0] : '0;
         end
         #1;
         for (int i = 0; i < NSRC; i++) begin
            if (src_pop[i])
               check((i == int'(cfg_src)) && src_valid[i], "R1 pop legality",
                     longint'(src_pop), longint'(1 << cfg_src));
         end
         pending = src_pop;
      end
   end

   // converter-side reference comparison, every output clock
   always @(negedge dac_clk) begin
      if (rst_n) begin
         if (cfg_dual) begin
            if (dac_ch0 != prev0 || dac_ch1 != prev1) begin
               if (mdl_q.size() == 0) begin
                  check(1'b0, "R6 change with nothing queued", longint'(dac_ch0), longint'(prev0));
               end else begin
                  logic [WW-1:0] w;
                  w = mdl_q.pop_front();
                  pops_seen++;
                  check(dac_ch0 == w[SW-1:0], "R4 ch0 low half", longint'(dac_ch0), longint'(w[SW-1:0]));
                  check(dac_ch1 == w[WW-1:SW], "R4 ch1 high half", longint'(dac_ch1), longint'(w[WW-1:SW]));
               end
            end
         end else begin
            check(dac_ch1 == prev1, "R5 ch1 kept in single mode", longint'(dac_ch1), longint'(prev1));
            if (dac_ch0 != prev0) begin
               if (mdl_q.size() == 0) begin
                  check(1'b0, "R6 change with nothing queued", longint'(dac_ch0), longint'(prev0));
               end else begin
                  logic [WW-1:0] w;
                  w = mdl_q.pop_front();
                  pops_seen++;
                  check(dac_ch0 == w[SW-1:0], "R5 ch0 low half", longint'(dac_ch0), longint'(w[SW-1:0]));
               end
            end
         end
         prev0 = dac_ch0;
         prev1 = dac_ch1;
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge sys_clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      logic [SW-1:0] h0, h1;
      wait_sys(5);
      rst_n = 1'b1;
      wait_sys(2);
      // R7: state after reset
      check(dac_ch0 == '0, "R7 ch0 reset", longint'(dac_ch0), 0);
      check(dac_ch1 == '0, "R7 ch1 reset", longint'(dac_ch1), 0);
      check(led_underflow == 1'b0, "R7 led reset", longint'(led_underflow), 0);
      check(src_pop == '0, "R7 no pop", longint'(src_pop), 0);

      // R3 and R1: fill with the output clock stopped
      cfg_src = 2'd1;
      push_src(1, DEPTH + 4);
      push_src(0, 2);
      wait_sys(40);
      check(pop_total == DEPTH, "R3 fill stops at depth", longint'(pop_total), DEPTH);
      check(srcq[1].size() == 4, "R3 words left in host queue", longint'(srcq[1].size()), 4);
      check(srcq[0].size() == 2, "R1 unselected queue untouched", longint'(srcq[0].size()), 2);
      check(led_underflow == 1'b0, "R8 no underflow no led", longint'(led_underflow), 0);

      // R2/R4: dual-channel drain
      dac_run = 1'b1;
      wait_sys(300);
      check(mdl_q.size() == 0 && srcq[1].size() == 0, "R2 first block drained",
            longint'(mdl_q.size() + srcq[1].size()), 0);
      check(pops_seen == DEPTH + 4, "R2 first block count", longint'(pops_seen), DEPTH + 4);

      // paced and burst streaming from another queue
      cfg_src = 2'd2;
      for (int k = 0; k < 20; k++) begin
         push_src(2, 1);
         wait_sys(7);
      end
      push_src(2, 30);
      wait_sys(500);
      check(mdl_q.size() == 0 && srcq[2].size() == 0, "R2 stream drained",
            longint'(mdl_q.size() + srcq[2].size()), 0);
      check(pops_seen == DEPTH + 4 + 50, "R2 stream count", longint'(pops_seen), DEPTH + 54);

      // single-channel mode
      dac_run = 1'b0;
      wait_sys(20);
      cfg_dual = 1'b0;
      push_src(2, 15);
      wait_sys(20);
      dac_run = 1'b1;
      wait_sys(300);
      check(pops_seen == DEPTH + 4 + 65, "R5 single mode count", longint'(pops_seen), DEPTH + 69);
      check(srcq[0].size() == 2, "R1 unselected queue still full", longint'(srcq[0].size()), 2);

      // R6: hold with empty FIFO
      h0 = dac_ch0;
      h1 = dac_ch1;
      wait_sys(80);
      check(dac_ch0 == h0, "R6 ch0 held", longint'(dac_ch0), longint'(h0));
      check(dac_ch1 == h1, "R6 ch1 held", longint'(dac_ch1), longint'(h1));

      // R8: indicator on while underflowing, then stretch after the last one
      check(led_underflow == 1'b1, "R8 led on during underflow", longint'(led_underflow), 1);
      dac_run = 1'b0;
      wait_sys(2);
      while ($time < last_pos + time'((STRETCH - 10) * 10)) @(posedge sys_clk);
      @(negedge sys_clk);
      check(led_underflow == 1'b1, "R8 led still stretched", longint'(led_underflow), 1);
      while ($time < last_pos + time'((STRETCH + 10) * 10)) @(posedge sys_clk);
      @(negedge sys_clk);
      check(led_underflow == 1'b0, "R8 led off after stretch", longint'(led_underflow), 0);

      finish_run();
   end
endmodule